// File: doc/BRIEF.md
# Memory Device Start-Up Sequencer

This block sits on the controller side of a DRAM interface. It walks the attached memory device through its mandatory power-up order. When a power-good input reports stable supplies, the sequencer holds the device reset pin low for a minimum time. It keeps the pin low for a further run of idle clocks, then releases it. It waits a long idle period, then writes three mode registers with fixed spacing between them. An optional read-training step follows, and the block finally raises a ready flag. Mode-register contents come from configuration inputs. For the second mode-register write, the sequencer forces the DLL-reset bit and the long impedance-calibration request bit to one.

Every wait is counted in clock cycles by a single shared down-counter. It is reloaded on each state entry, and only the idle command is driven while a wait runs. The minimum reset hold is given in nanoseconds together with the clock frequency in kHz. It is converted to cycles at elaboration, rounding up so the hold is never cut short. Dropping power-good, or asserting the controller reset, returns the block to the reset-low state and clears ready.

Top module: `dram_init_seq`

## Requirements
- R1: After power-good is seen high in the idle state, the device reset output stays low for HOLD_CYC = ceil(HOLD_NS x CLK_KHZ / 1e6) cycles while the command is idle (cmd 2'b00).
- R2: After the hold, reset stays low for a further PRE_NOP cycles of idle commands and is then driven high.
- R3: After reset is released, exactly POST_NOP idle cycles pass before the first mode-register write, and no mode-register write is ever issued while reset is low.
- R4: The first write is cmd 2'b01 with mr_sel 2'b00 and data cfg_mr0_i. dq_hiz_o is high from reset up to and including that cycle and low afterwards.
- R5: After the MR0 write, MRSC idle cycles pass, and then the MR1 write (mr_sel 2'b01) is issued.
- R6: The MR1 write carries cfg_mr1_i with bits DLL_RST_BIT and ZQ_CAL_BIT forced to 1.
- R7: After the MR1 write, LOCK_NOP idle cycles pass, and then the MR2 write (mr_sel 2'b10, data cfg_mr2_i) is issued.
- R8: With train_en_i high, train_start_o is a one-cycle pulse in the cycle after the MR2 write. ready_o rises in the cycle after train_done_i is sampled high, and not before.
- R9: With train_en_i low, ready_o rises in the cycle after the MR2 write. It then stays high with idle commands while power-good remains high.
- R10: power-good low at a clock edge puts the block in the reset-low state in the next cycle: reset low, ready low, dq_hiz_o high. The sequence restarts from R1 when power-good returns.
- R11: While rst_n is low, the outputs are: device reset low, cmd idle, ready low, train_start low, dq_hiz_o high.
- R12: Whenever cmd_o is idle, mr_sel_o and mr_val_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset, released synchronously |
| pwr_good_i | input | 1 | Supplies stable |
| train_en_i | input | 1 | Run read training after the MR2 write |
| train_done_i | input | 1 | Read training finished |
| cfg_mr0_i | input | MR_W | MR0 contents |
| cfg_mr1_i | input | MR_W | MR1 contents before forced bits |
| cfg_mr2_i | input | MR_W | MR2 contents |
| dram_rst_n_o | output | 1 | Active-low device reset |
| cmd_o | output | 2 | 2'b00 idle, 2'b01 mode-register write |
| mr_sel_o | output | 2 | Target mode register during a write |
| mr_val_o | output | MR_W | Mode-register data during a write |
| dq_hiz_o | output | 1 | Data and strobe pins kept high-impedance |
| train_start_o | output | 1 | Read-training start pulse |
| ready_o | output | 1 | Device ready for normal traffic |

## Verification
The properties assume that rst_n is released synchronously and that the configuration inputs hold steady during the mode-register writes. They also assume train_done_i is meaningful only while training runs. The stimulus changes every input shortly after a rising edge and holds the configuration words fixed for each pass. It raises train_done_i only after a start pulse has been seen, except in one pass that holds it high beforehand to test done arriving with start. The counter-based properties rely on power-good staying high through each wait. Power-good drops are placed mid-wait and in the ready state so that the restart paths are also exercised.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [3:0] {
    ST_OFF   = 4'd0,
    ST_HOLD  = 4'd1,
    ST_PRE   = 4'd2,
    ST_POST  = 4'd3,
    ST_MR0   = 4'd4,
    ST_GAP   = 4'd5,
    ST_MR1   = 4'd6,
    ST_LOCK  = 4'd7,
    ST_MR2   = 4'd8,
    ST_TRAIN = 4'd9,
    ST_READY = 4'd10
  } init_st_e;

  localparam logic [1:0] CMD_NOP = 2'b00;
  localparam logic [1:0] CMD_MRS = 2'b01;

  function automatic longint unsigned ceil_div(input longint unsigned num,
                                               input longint unsigned den);
    return (num + den - 64'd1) / den;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dinit_wait_ctr.sv
module dinit_wait_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dinit_fsm.sv
module dinit_fsm
  import dinit_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned HOLD_CYC = 4,
  parameter int unsigned PRE_NOP  = 4,
  parameter int unsigned POST_NOP = 4,
  parameter int unsigned MRSC     = 4,
  parameter int unsigned LOCK_NOP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             expired,
  input  logic             train_en,
  input  logic             train_done,
  output init_st_e         state,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             train_start
);

  init_st_e st_q;
  init_st_e st_d;
  logic     start_q;
  logic     start_d;

  always_comb begin
    st_d = st_q;
    if (!pwr_good) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:   st_d = ST_HOLD;
        ST_HOLD:  if (expired) st_d = ST_PRE;
        ST_PRE:   if (expired) st_d = ST_POST;
        ST_POST:  if (expired) st_d = ST_MR0;
        ST_MR0:   st_d = ST_GAP;
        ST_GAP:   if (expired) st_d = ST_MR1;
        ST_MR1:   st_d = ST_LOCK;
        ST_LOCK:  if (expired) st_d = ST_MR2;
        ST_MR2:   st_d = train_en ? ST_TRAIN : ST_READY;
        ST_TRAIN: if (train_done) st_d = ST_READY;
        ST_READY: st_d = ST_READY;
        default:  st_d = ST_OFF;
      endcase
    end
  end

  // Counter reload on every state change, with the new state's length minus one
  assign load = (st_d != st_q);

  always_comb begin
    case (st_d)
      ST_HOLD: load_val = CNT_W'(HOLD_CYC - 1);
      ST_PRE:  load_val = CNT_W'(PRE_NOP - 1);
      ST_POST: load_val = CNT_W'(POST_NOP - 1);
      ST_GAP:  load_val = CNT_W'(MRSC - 1);
      ST_LOCK: load_val = CNT_W'(LOCK_NOP - 1);
      default: load_val = '0;
    endcase
  end

  assign start_d = (st_d == ST_TRAIN) && (st_q != ST_TRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
    end
  end

  assign state       = st_q;
  assign train_start = start_q;

endmodule

// File: rtl/dinit_cmd_drv.sv
module dinit_cmd_drv
  import dinit_pkg::*;
#(
  parameter int unsigned MR_W        = 18,
  parameter int unsigned DLL_RST_BIT = 7,
  parameter int unsigned ZQ_CAL_BIT  = 8
) (
  input  init_st_e          state,
  input  logic [MR_W-1:0]   cfg_mr0,
  input  logic [MR_W-1:0]   cfg_mr1,
  input  logic [MR_W-1:0]   cfg_mr2,
  output logic              dram_rst_n,
  output logic [1:0]        cmd,
  output logic [1:0]        mr_sel,
  output logic [MR_W-1:0]   mr_val,
  output logic              dq_hiz,
  output logic              ready
);

  localparam logic [MR_W-1:0] MR1_FORCE =
    (MR_W'(1) << DLL_RST_BIT) | (MR_W'(1) << ZQ_CAL_BIT);

  always_comb begin
    cmd    = CMD_NOP;
    mr_sel = 2'b00;
    mr_val = '0;
    case (state)
      ST_MR0: begin
        cmd    = CMD_MRS;
        mr_sel = 2'b00;
        mr_val = cfg_mr0;
      end
      ST_MR1: begin
        cmd    = CMD_MRS;
        mr_sel = 2'b01;
        mr_val = cfg_mr1 | MR1_FORCE;
      end
      ST_MR2: begin
        cmd    = CMD_MRS;
        mr_sel = 2'b10;
        mr_val = cfg_mr2;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (state)
      ST_OFF, ST_HOLD, ST_PRE: dram_rst_n = 1'b0;
      default:                 dram_rst_n = 1'b1;
    endcase
  end

  always_comb begin
    case (state)
      ST_OFF, ST_HOLD, ST_PRE, ST_POST, ST_MR0: dq_hiz = 1'b1;
      default:                                 dq_hiz = 1'b0;
    endcase
  end

  assign ready = (state == ST_READY);

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dinit_pkg::*;
#(
  parameter int unsigned HOLD_NS     = 200000,
  parameter int unsigned CLK_KHZ     = 100000,
  parameter int unsigned PRE_NOP     = 100,
  parameter int unsigned POST_NOP    = 10000,
  parameter int unsigned MRSC        = 4,
  parameter int unsigned LOCK_NOP    = 512,
  parameter int unsigned MR_W        = 18,
  parameter int unsigned DLL_RST_BIT = 7,
  parameter int unsigned ZQ_CAL_BIT  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good_i,
  input  logic            train_en_i,
  input  logic            train_done_i,
  input  logic [MR_W-1:0] cfg_mr0_i,
  input  logic [MR_W-1:0] cfg_mr1_i,
  input  logic [MR_W-1:0] cfg_mr2_i,
  output logic            dram_rst_n_o,
  output logic [1:0]      cmd_o,
  output logic [1:0]      mr_sel_o,
  output logic [MR_W-1:0] mr_val_o,
  output logic            dq_hiz_o,
  output logic            train_start_o,
  output logic            ready_o
);

  // Hold time in cycles, rounded up so it is never shorter than asked
  localparam int unsigned HOLD_CYC =
    32'(ceil_div(64'(HOLD_NS) * 64'(CLK_KHZ), 64'd1000000));
  localparam int unsigned MAX_WAIT =
    umax(umax(umax(HOLD_CYC, PRE_NOP), umax(POST_NOP, MRSC)), LOCK_NOP);
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

  init_st_e         state;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  dinit_fsm #(
    .CNT_W   (CNT_W),
    .HOLD_CYC(HOLD_CYC),
    .PRE_NOP (PRE_NOP),
    .POST_NOP(POST_NOP),
    .MRSC    (MRSC),
    .LOCK_NOP(LOCK_NOP)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good_i),
    .expired    (expired),
    .train_en   (train_en_i),
    .train_done (train_done_i),
    .state      (state),
    .load       (load),
    .load_val   (load_val),
    .train_start(train_start_o)
  );

  dinit_wait_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  dinit_cmd_drv #(
    .MR_W       (MR_W),
    .DLL_RST_BIT(DLL_RST_BIT),
    .ZQ_CAL_BIT (ZQ_CAL_BIT)
  ) u_drv (
    .state     (state),
    .cfg_mr0   (cfg_mr0_i),
    .cfg_mr1   (cfg_mr1_i),
    .cfg_mr2   (cfg_mr2_i),
    .dram_rst_n(dram_rst_n_o),
    .cmd       (cmd_o),
    .mr_sel    (mr_sel_o),
    .mr_val    (mr_val_o),
    .dq_hiz    (dq_hiz_o),
    .ready     (ready_o)
  );

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int unsigned MR_W        = 18,
  parameter int unsigned DLL_RST_BIT = 7,
  parameter int unsigned ZQ_CAL_BIT  = 8,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned PRE_NOP     = 4,
  parameter int unsigned POST_NOP    = 4,
  parameter int unsigned MRSC        = 4,
  parameter int unsigned LOCK_NOP    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwr_good_i,
  input logic            dram_rst_n_o,
  input logic [1:0]      cmd_o,
  input logic [1:0]      mr_sel_o,
  input logic [MR_W-1:0] mr_val_o,
  input logic            dq_hiz_o,
  input logic            train_start_o,
  input logic            ready_o
);

  logic [31:0] low_cnt;
  logic [31:0] high_cnt;
  logic [31:0] since_mrs;
  logic        is_mrs;

  assign is_mrs = (cmd_o == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      high_cnt  <= '0;
      since_mrs <= '0;
    end else begin
      low_cnt   <= (!dram_rst_n_o && pwr_good_i && low_cnt != '1) ? low_cnt + 32'd1 : '0;
      high_cnt  <= (dram_rst_n_o && high_cnt != '1) ? high_cnt + 32'd1 : '0;
      since_mrs <= is_mrs ? '0 : ((since_mrs != '1) ? since_mrs + 32'd1 : since_mrs);
    end
  end

  a_r1_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dram_rst_n_o) && pwr_good_i) |-> (low_cnt >= HOLD_CYC + PRE_NOP));

  a_r3_post_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mr_sel_o == 2'b00) |-> (high_cnt >= POST_NOP));

  a_r3_mrs_released: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> dram_rst_n_o);

  a_r4_hiz_at_mr0: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mr_sel_o == 2'b00) |-> dq_hiz_o);

  a_r4_hiz_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_hiz_o) |-> $past(is_mrs && mr_sel_o == 2'b00));

  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mr_sel_o == 2'b01) |-> (since_mrs >= MRSC));

  a_r6_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mr_sel_o == 2'b01) |-> (mr_val_o[DLL_RST_BIT] && mr_val_o[ZQ_CAL_BIT]));

  a_r7_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && mr_sel_o == 2'b10) |-> (since_mrs >= LOCK_NOP));

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    train_start_o |=> !train_start_o);

  a_r8_start_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    train_start_o |-> !ready_o);

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && pwr_good_i) |=> ready_o);

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cmd_o == 2'b00));

  a_r10_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> (!dram_rst_n_o && !ready_o && dq_hiz_o));

  a_r12_idle_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'b00) |-> (mr_sel_o == 2'b00 && mr_val_o == '0));

endmodule

bind dram_init_seq dram_init_seq_chk #(
  .MR_W       (MR_W),
  .DLL_RST_BIT(DLL_RST_BIT),
  .ZQ_CAL_BIT (ZQ_CAL_BIT),
  .HOLD_CYC   (HOLD_CYC),
  .PRE_NOP    (PRE_NOP),
  .POST_NOP   (POST_NOP),
  .MRSC       (MRSC),
  .LOCK_NOP   (LOCK_NOP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_good_i   (pwr_good_i),
  .dram_rst_n_o (dram_rst_n_o),
  .cmd_o        (cmd_o),
  .mr_sel_o     (mr_sel_o),
  .mr_val_o     (mr_val_o),
  .dq_hiz_o     (dq_hiz_o),
  .train_start_o(train_start_o),
  .ready_o      (ready_o)
);

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD_NS    = 2500;
  localparam int CLK_KHZ    = 3300;
  localparam int PRE_NOP    = 5;
  localparam int POST_NOP   = 12;
  localparam int MRSC       = 3;
  localparam int LOCK_NOP   = 6;
  localparam int MR_W       = 18;
  localparam int DLL_BIT    = 7;
  localparam int ZQ_BIT     = 8;
  localparam int WATCHDOG   = 5000;

  // Rounded-up hold cycles, worked out independently: 2500 ns at 3.3 MHz is 8.25 -> 9
  localparam longint HOLD_PROD = longint'(HOLD_NS) * longint'(CLK_KHZ);
  localparam int EXP_HOLD = int'(HOLD_PROD / 1000000) + ((HOLD_PROD % 1000000) != 0 ? 1 : 0);

  // Model phases
  localparam int P_OFF = 0, P_HOLD = 1, P_PRE = 2, P_POST = 3, P_MR0 = 4, P_GAP = 5,
                 P_MR1 = 6, P_LOCK = 7, P_MR2 = 8, P_TRAIN = 9, P_READY = 10;

  logic            clk;
  logic            rst_n;
  logic            pwr_good;
  logic            train_en;
  logic            train_done;
  logic [MR_W-1:0] cfg0, cfg1, cfg2;
  logic            dram_rst_n;
  logic [1:0]      cmd;
  logic [1:0]      mr_sel;
  logic [MR_W-1:0] mr_val;
  logic            dq_hiz;
  logic            train_start;
  logic            ready;

  int checks;
  int errors;
  int cycles;

  dram_init_seq #(
    .HOLD_NS    (HOLD_NS),
    .CLK_KHZ    (CLK_KHZ),
    .PRE_NOP    (PRE_NOP),
    .POST_NOP   (POST_NOP),
    .MRSC       (MRSC),
    .LOCK_NOP   (LOCK_NOP),
    .MR_W       (MR_W),
    .DLL_RST_BIT(DLL_BIT),
    .ZQ_CAL_BIT (ZQ_BIT)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good_i   (pwr_good),
    .train_en_i   (train_en),
    .train_done_i (train_done),
    .cfg_mr0_i    (cfg0),
    .cfg_mr1_i    (cfg1),
    .cfg_mr2_i    (cfg2),
    .dram_rst_n_o (dram_rst_n),
    .cmd_o        (cmd),
    .mr_sel_o     (mr_sel),
    .mr_val_o     (mr_val),
    .dq_hiz_o     (dq_hiz),
    .train_start_o(train_start),
    .ready_o      (ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_ph;
  int m_left;
  bit m_first;

  function automatic int phase_len(input int p);
    case (p)
      P_HOLD:  return EXP_HOLD;
      P_PRE:   return PRE_NOP;
      P_POST:  return POST_NOP;
      P_GAP:   return MRSC;
      P_LOCK:  return LOCK_NOP;
      default: return 1;
    endcase
  endfunction

  function automatic string ptag(input int p);
    case (p)
      P_OFF:   return "R10";
      P_HOLD:  return "R1";
      P_PRE:   return "R2";
      P_POST:  return "R3";
      P_MR0:   return "R4";
      P_GAP:   return "R5";
      P_MR1:   return "R6";
      P_LOCK:  return "R7";
      P_MR2:   return "R7";
      P_TRAIN: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic enter(input int p);
    m_ph     = p;
    m_left   = phase_len(p);
    m_first  = (p == P_TRAIN);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph    = P_OFF;
      m_left  = 0;
      m_first = 1'b0;
    end else begin
      m_first = 1'b0;
      if (!pwr_good) begin
        m_ph = P_OFF;
      end else if (m_ph == P_OFF) begin
        enter(P_HOLD);
      end else if (m_ph == P_TRAIN) begin
        if (train_done) enter(P_READY);
      end else if (m_ph == P_READY) begin
        m_ph = P_READY;
      end else if (m_ph == P_MR2) begin
        enter(train_en ? P_TRAIN : P_READY);
      end else if (m_left > 1) begin
        m_left--;
      end else begin
        enter(m_ph + 1);
      end
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    logic [1:0]      e_cmd;
    logic [1:0]      e_sel;
    logic [MR_W-1:0] e_val;
    string           t;
    t     = ptag(m_ph);
    e_cmd = 2'b00;
    e_sel = 2'b00;
    e_val = '0;
    if (m_ph == P_MR0) begin e_cmd = 2'b01; e_sel = 2'b00; e_val = cfg0; end
    if (m_ph == P_MR1) begin
      e_cmd = 2'b01; e_sel = 2'b01;
      e_val = cfg1 | (MR_W'(1) << DLL_BIT) | (MR_W'(1) << ZQ_BIT);
    end
    if (m_ph == P_MR2) begin e_cmd = 2'b10 - 2'b01; e_sel = 2'b10; e_val = cfg2; end
    if (!rst_n) t = "R11";
    check(t, "dram_rst_n", 64'(dram_rst_n), 64'(m_ph >= P_POST));
    check(t, "cmd", 64'(cmd), 64'(e_cmd));
    check((e_cmd == 2'b00) ? "R12" : t, "mr_sel", 64'(mr_sel), 64'(e_sel));
    check((e_cmd == 2'b00) ? "R12" : t, "mr_val", 64'(mr_val), 64'(e_val));
    check((m_ph <= P_MR0) ? t : "R4", "dq_hiz", 64'(dq_hiz), 64'(m_ph <= P_MR0));
    check(t, "ready", 64'(ready), 64'(m_ph == P_READY));
    check(t, "train_start", 64'(train_start), 64'(m_ph == P_TRAIN && m_first));
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_ready(input string req);
    int n;
    n = 0;
    while (ready !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(req, "ready reached", 64'(ready), 64'd1);
  endtask

  task automatic wait_mrs(input logic [1:0] sel);
    int n;
    n = 0;
    while (!(cmd === 2'b01 && mr_sel === sel) && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int low_n;
    int high_n;
    int n;
    checks     = 0;
    errors     = 0;
    cycles     = 0;
    rst_n      = 1'b0;
    pwr_good   = 1'b0;
    train_en   = 1'b0;
    train_done = 1'b0;
    cfg0       = 18'h0_1A5;
    cfg1       = 18'h0_000;
    cfg2       = 18'h3_C21;

    // R11: reset state
    step(3);
    @(negedge clk);
    check("R11", "dram_rst_n in reset", 64'(dram_rst_n), 64'd0);
    check("R11", "dq_hiz in reset", 64'(dq_hiz), 64'd1);
    check("R11", "ready in reset", 64'(ready), 64'd0);
    check("R11", "cmd in reset", 64'(cmd), 64'd0);

    step(1);
    rst_n = 1'b1;
    step(2);

    // Pass 1: no training, MR1 config all zero
    pwr_good = 1'b1;
    low_n = 0;
    @(negedge clk);
    while (dram_rst_n === 1'b0 && low_n < 300) begin
      low_n++;
      @(negedge clk);
    end
    // one idle cycle before the hold starts, then hold, then pre-release NOPs
    check("R1", "low cycles after power-good", 64'(low_n), 64'(1 + EXP_HOLD + PRE_NOP));
    high_n = 0;
    while (!(cmd === 2'b01) && high_n < 300) begin
      high_n++;
      @(negedge clk);
    end
    check("R3", "idle cycles before MR0", 64'(high_n), 64'(POST_NOP));
    check("R4", "first write targets MR0", 64'(mr_sel), 64'd0);
    @(negedge clk);
    check("R4", "dq_hiz after MR0", 64'(dq_hiz), 64'd0);
    wait_mrs(2'b01);
    check("R6", "DLL reset bit", 64'(mr_val[DLL_BIT]), 64'd1);
    check("R6", "calibration bit", 64'(mr_val[ZQ_BIT]), 64'd1);
    wait_mrs(2'b10);
    @(negedge clk);
    check("R9", "ready one cycle after MR2", 64'(ready), 64'd1);
    step(6);
    @(negedge clk);
    check("R9", "ready holds", 64'(ready), 64'd1);

    // R10: power loss in ready
    step(1);
    pwr_good = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "ready cleared", 64'(ready), 64'd0);
    check("R10", "reset low again", 64'(dram_rst_n), 64'd0);
    check("R10", "dq_hiz again", 64'(dq_hiz), 64'd1);

    // Pass 2: training enabled, power lost mid lock wait
    cfg0     = 18'h2_0F0;
    cfg1     = 18'h1_00C;
    cfg2     = 18'h0_7E3;
    train_en = 1'b1;
    step(2);
    pwr_good = 1'b1;
    wait_mrs(2'b01);
    step(3);
    pwr_good = 1'b0;
    step(2);
    @(negedge clk);
    check("R10", "restart from reset-low", 64'(dram_rst_n), 64'd0);
    step(1);
    pwr_good = 1'b1;
    n = 0;
    while (train_start !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
    end
    check("R8", "start pulse seen", 64'(train_start), 64'd1);
    check("R8", "not ready at start", 64'(ready), 64'd0);
    @(negedge clk);
    check("R8", "start pulse one cycle", 64'(train_start), 64'd0);
    step(1);
    train_done = 1'b1;
    @(negedge clk);
    check("R8", "ready waits for done edge", 64'(ready), 64'd0);
    step(1);
    train_done = 1'b0;
    @(negedge clk);
    check("R8", "ready after done", 64'(ready), 64'd1);
    step(3);

    // Pass 3: controller reset during post-release wait, done held high early
    pwr_good = 1'b0;
    step(1);
    pwr_good = 1'b1;
    n = 0;
    while (dram_rst_n !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
    end
    step(4);
    rst_n = 1'b0;
    #1;
    check("R11", "async reset drops device reset", 64'(dram_rst_n), 64'd0);
    check("R11", "async reset restores dq_hiz", 64'(dq_hiz), 64'd1);
    step(2);
    rst_n      = 1'b1;
    train_done = 1'b1;
    wait_ready("R8");
    step(4);
    train_done = 1'b0;
    step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule